// File: doc/BRIEF.md
# ADC Sample Sequencer FIFOs

This block holds the digital side of a four-channel sample sequencer for an analogue-to-digital converter. Each sequencer owns a 16-deep result FIFO, a channel-selection word, a free control word and a readable status word that packs both FIFO pointers with the empty and full flags. A single trigger input, usually a periodic timer pulse, makes every enabled sequencer whose event selector names the timer store one new result. The converter itself is stood in for by a linear-congruential noise source, so software sees plausible values that vary slightly.

Software reaches the block through a simple register port. Global registers sit at low offsets. Each sequencer has its own 32-byte window starting at offset 0x40. A read of a sequencer's data register pops that FIFO. Each sequencer drives its own interrupt line, and each line can be masked.

Top module: `adc_seq_fifo_top`

## Requirements
- R1: After reset every sequencer status word reads 0x100, and the enable, raw-interrupt, mask and event-select registers read 0. The noise state resets to 0.
- R2: The status word at window offset 0x0C carries the read pointer in bits 3:0 and the write pointer in bits 7:4. It carries empty at bit 8 and full at bit 12, and empty and full are never both set.
- R3: On a cycle with the trigger high, sequencer n is served only if enable bit n (register 0x00) is set and event field n (register 0x14, bits 4n+3:4n) equals 5. When the trigger is low no sequencer is served.
- R4: Each served sequencer advances noise to noise*314159+1 modulo 2^32 and stores 0x200 plus bits 18:16 of the new noise. When several sequencers are served on one trigger, they are handled in ascending order within that cycle, each taking the next noise value. Noise advances even when the store is dropped.
- R5: A store into a full FIFO is dropped and leaves the status unchanged. Otherwise a store clears empty and advances the write pointer modulo 16, and it sets full when the new write pointer equals the read pointer.
- R6: Reading window offset 0x08 returns the entry at the read pointer and pops the FIFO. A pop clears full, advances the read pointer modulo 16, and sets empty when the new read pointer equals the write pointer. A pop of an empty FIFO returns the entry at the read pointer and leaves the status unchanged.
- R7: Serving sequencer n sets raw bit n (register 0x04, read-only, writes ignored). Interrupt output n is raw bit n AND mask bit n (register 0x08, 4 bits).
- R8: Register 0x0C reads raw AND mask. Writing it clears the raw bits written as 1, and a set in the same cycle takes priority over the clear.
- R9: A write to window offset 0x00 stores the data AND 0x33333333. Window offset 0x04 stores the full 32-bit word. Both registers belong to their own sequencer only.
- R10: The enable register keeps only its low 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| trigPulse | input | 1 | Timer trigger; each high cycle is one event |
| busAddr | input | 12 | Byte offset of the register access |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe (pops on the data register) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| irqOut | output | 4 | Masked per-sequencer interrupts |

## Verification
A register write, a pop and a served trigger all change state on the rising edge that samples the strobe. Status, raw bits and irqOut are therefore due one edge after the stimulus. Read data is registered on the edge that samples busRe and holds until the next read. The bench drives every input on the falling edge and samples on the following falling edge, so each result is read exactly one edge after it is due, never in the same edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  parameter int SEQ_N      = 4;
  parameter int FIFO_DEPTH = 16;
  parameter int PTR_W      = $clog2(FIFO_DEPTH);
  parameter int SAMPLE_W   = 12;
  // status word layout: {full, pad, empty, wrPtr, rdPtr}
  parameter int EMPTY_BIT  = 2 * PTR_W;
  parameter int FULL_BIT   = EMPTY_BIT + 4;
  parameter int STAT_W     = FULL_BIT + 1;
  // offsets inside a sequencer window
  parameter logic [4:0] SUB_MUX  = 5'h00;
  parameter logic [4:0] SUB_CTL  = 5'h04;
  parameter logic [4:0] SUB_DATA = 5'h08;
  parameter logic [4:0] SUB_STAT = 5'h0C;

  typedef logic [STAT_W-1:0] fifoStat_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [SEQ_N-1:0] push;
    logic [SEQ_N-1:0] pop;
  } seqStrobe_t;
endpackage

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo
  import adc_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                pushEn,
  input  logic                popEn,
  input  logic [SAMPLE_W-1:0] pushData,
  output logic [SAMPLE_W-1:0] headData,
  output fifoStat_t           statWord
);
  logic [SAMPLE_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]    rdPtr, wrPtr, rdNext, wrNext;
  logic                emptyQ, fullQ, pushOk, popOk;

  assign pushOk = pushEn & ~fullQ;
  assign popOk  = popEn & ~emptyQ;
  assign rdNext = popOk  ? rdPtr + 1'b1 : rdPtr;
  assign wrNext = pushOk ? wrPtr + 1'b1 : wrPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      emptyQ <= 1'b1;
      fullQ  <= 1'b0;
    end else begin
      rdPtr <= rdNext;
      wrPtr <= wrNext;
      case ({pushOk, popOk})
        2'b10: begin
          emptyQ <= 1'b0;
          fullQ  <= (wrNext == rdPtr);
        end
        2'b01: begin
          fullQ  <= 1'b0;
          emptyQ <= (rdNext == wrPtr);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  assign headData = mem[rdPtr];
  assign statWord = {fullQ, 3'b000, emptyQ, wrPtr, rdPtr};
endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter logic [31:0]         NOISE_MUL   = 32'd314159,
  parameter logic [31:0]         NOISE_INC   = 32'd1,
  parameter logic [SAMPLE_W-1:0] SAMPLE_BASE = SAMPLE_W'(12'h200)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  seqStrobe_t                       strobe,
  output logic [SEQ_N-1:0][SAMPLE_W-1:0]   headData,
  output fifoStat_t [SEQ_N-1:0]            fifoStat
);
  localparam int NOISE_LSB = 16;
  localparam int SEL_W     = 3;

  logic [31:0]                     noiseQ;
  logic [SEQ_N:0][31:0]            noiseChain;
  logic [SEQ_N-1:0][SAMPLE_W-1:0]  sampleVal;

  // ascending service order: each served sequencer takes the next value
  always_comb begin
    noiseChain[0] = noiseQ;
    for (int n = 0; n < SEQ_N; n++) begin
      if (strobe.push[n]) noiseChain[n+1] = noiseChain[n] * NOISE_MUL + NOISE_INC;
      else                noiseChain[n+1] = noiseChain[n];
      sampleVal[n] = SAMPLE_BASE + SAMPLE_W'(noiseChain[n+1][NOISE_LSB +: SEL_W]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) noiseQ <= '0;
    else       noiseQ <= noiseChain[SEQ_N];
  end

  for (genvar g = 0; g < SEQ_N; g++) begin : g_fifo
    adc_seq_fifo fifo_i (
      .clk      (clk),
      .rstN     (rstN),
      .pushEn   (strobe.push[g]),
      .popEn    (strobe.pop[g]),
      .pushData (sampleVal[g]),
      .headData (headData[g]),
      .statWord (fifoStat[g])
    );
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 32,
  parameter logic [3:0]  TIMER_EVT = 4'h5,
  parameter logic [DATA_W-1:0] MUX_KEEP = DATA_W'(32'h3333_3333)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           trigPulse,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic                           busWe,
  input  logic                           busRe,
  input  logic [DATA_W-1:0]              busWdata,
  output logic [DATA_W-1:0]              busRdata,
  output logic [SEQ_N-1:0]               irqOut,
  output seqStrobe_t                     strobe,
  input  logic [SEQ_N-1:0][SAMPLE_W-1:0] headData,
  input  fifoStat_t [SEQ_N-1:0]          fifoStat
);
  localparam int IDX_W     = (SEQ_N > 1) ? $clog2(SEQ_N) : 1;
  localparam int WIN_SHIFT = 5;
  localparam int EVT_W     = 4 * SEQ_N;
  localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(12'h040);
  localparam logic [ADDR_W-1:0] WIN_SPAN = ADDR_W'(SEQ_N << WIN_SHIFT);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] A_EVENT  = ADDR_W'(12'h014);

  logic [SEQ_N-1:0]             enableQ, rawQ, maskQ, clrBits, serve;
  logic [EVT_W-1:0]             eventQ;
  logic [SEQ_N-1:0][DATA_W-1:0] muxQ, ctlQ;
  logic [ADDR_W-1:0]            winOff;
  logic [IDX_W-1:0]             seqIdx;
  logic [WIN_SHIFT-1:0]         subOff;
  logic                         seqHit;
  logic [DATA_W-1:0]            rdNext;

  assign winOff = busAddr - WIN_BASE;
  assign seqHit = (busAddr >= WIN_BASE) && (winOff < WIN_SPAN);
  assign seqIdx = winOff[WIN_SHIFT +: IDX_W];
  assign subOff = winOff[WIN_SHIFT-1:0];

  // trigger routing and pop strobes
  for (genvar g = 0; g < SEQ_N; g++) begin : g_route
    assign serve[g] = trigPulse & enableQ[g] & (eventQ[4*g +: 4] == TIMER_EVT);
    assign strobe.pop[g] = busRe & seqHit & (seqIdx == IDX_W'(g)) & (subOff == SUB_DATA);
  end
  assign strobe.push = serve;

  assign clrBits = (busWe && !seqHit && busAddr == A_CLEAR) ? busWdata[SEQ_N-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
      maskQ   <= '0;
      eventQ  <= '0;
      rawQ    <= '0;
      muxQ    <= '0;
      ctlQ    <= '0;
    end else begin
      rawQ <= (rawQ & ~clrBits) | serve;
      if (busWe) begin
        if (seqHit) begin
          if (subOff == SUB_MUX) muxQ[seqIdx] <= busWdata & MUX_KEEP;
          if (subOff == SUB_CTL) ctlQ[seqIdx] <= busWdata;
        end else begin
          if (busAddr == A_ENABLE) enableQ <= busWdata[SEQ_N-1:0];
          if (busAddr == A_MASK)   maskQ   <= busWdata[SEQ_N-1:0];
          if (busAddr == A_EVENT)  eventQ  <= busWdata[EVT_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (seqHit) begin
      case (subOff)
        SUB_MUX:  rdNext = muxQ[seqIdx];
        SUB_CTL:  rdNext = ctlQ[seqIdx];
        SUB_DATA: rdNext = DATA_W'(headData[seqIdx]);
        SUB_STAT: rdNext = DATA_W'(fifoStat[seqIdx]);
        default:  rdNext = '0;
      endcase
    end else begin
      case (busAddr)
        A_ENABLE: rdNext = DATA_W'(enableQ);
        A_RAW:    rdNext = DATA_W'(rawQ);
        A_MASK:   rdNext = DATA_W'(maskQ);
        A_CLEAR:  rdNext = DATA_W'(rawQ & maskQ);
        A_EVENT:  rdNext = DATA_W'(eventQ);
        default:  rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      busRdata <= '0;
    else if (busRe) busRdata <= rdNext;
  end

  assign irqOut = rawQ & maskQ;
endmodule

// File: rtl/adc_seq_fifo_top.sv
module adc_seq_fifo_top
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigPulse,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [SEQ_N-1:0]  irqOut
);
  seqStrobe_t                     strobe;
  logic [SEQ_N-1:0][SAMPLE_W-1:0] headData;
  fifoStat_t [SEQ_N-1:0]          fifoStat;

  adc_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .trigPulse (trigPulse),
    .busAddr   (busAddr),
    .busWe     (busWe),
    .busRe     (busRe),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .irqOut    (irqOut),
    .strobe    (strobe),
    .headData  (headData),
    .fifoStat  (fifoStat)
  );

  adc_seq_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .headData (headData),
    .fifoStat (fifoStat)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  trigPulse,
  input seqStrobe_t            strobe,
  input fifoStat_t [SEQ_N-1:0] fifoStat
);
  p_trig_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    !trigPulse |-> (strobe.push == '0));

  for (genvar g = 0; g < SEQ_N; g++) begin : g_seq
    p_no_dual_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
      !(fifoStat[g][FULL_BIT] && fifoStat[g][EMPTY_BIT]));

    p_drop_full_r5: assert property (@(posedge clk) disable iff (!rstN)
      (fifoStat[g][FULL_BIT] && strobe.push[g] && !strobe.pop[g]) |=> $stable(fifoStat[g]));

    p_push_clears_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.push[g] && !strobe.pop[g]) |=> !fifoStat[g][EMPTY_BIT]);

    p_hold_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
      (fifoStat[g][EMPTY_BIT] && strobe.pop[g] && !strobe.push[g]) |=> $stable(fifoStat[g]));

    p_pop_clears_full_r6: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.pop[g] && !strobe.push[g] && !fifoStat[g][EMPTY_BIT]) |=> !fifoStat[g][FULL_BIT]);
  end
endmodule

bind adc_seq_fifo_top adc_seq_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .trigPulse (trigPulse),
  .strobe    (strobe),
  .fifoStat  (fifoStat)
);

// File: tb/adc_seq_fifo_top_tb_top.sv
module adc_seq_fifo_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trigPulse = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  irqOut;

  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_fifo_top dut_i (
    .clk(clk), .rstN(rstN), .trigPulse(trigPulse), .busAddr(busAddr),
    .busWe(busWe), .busRe(busRe), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [1:0]  op;    // 0 write, 1 read and compare
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VEC [NVEC] = '{
    '{2'd1, 12'h000, 32'h0,          32'h0,          4'd1},  // R1 enable reset
    '{2'd1, 12'h004, 32'h0,          32'h0,          4'd1},  // R1 raw reset
    '{2'd1, 12'h04C, 32'h0,          32'h100,        4'd1},  // R1 seq0 status
    '{2'd1, 12'h0AC, 32'h0,          32'h100,        4'd1},  // R1 seq3 status
    '{2'd0, 12'h040, 32'hFFFF_FFFF,  32'h0,          4'd9},
    '{2'd1, 12'h040, 32'h0,          32'h3333_3333,  4'd9},  // R9 mux mask
    '{2'd0, 12'h064, 32'hDEAD_BEEF,  32'h0,          4'd9},
    '{2'd1, 12'h064, 32'h0,          32'hDEAD_BEEF,  4'd9},  // R9 control word
    '{2'd1, 12'h044, 32'h0,          32'h0,          4'd9},  // R9 other window untouched
    '{2'd0, 12'h000, 32'hFFFF_FFFF,  32'h0,          4'd10},
    '{2'd1, 12'h000, 32'h0,          32'hF,          4'd10}, // R10 enable width
    '{2'd0, 12'h004, 32'hF,          32'h0,          4'd7},
    '{2'd1, 12'h004, 32'h0,          32'h0,          4'd7},  // R7 raw read-only
    '{2'd0, 12'h008, 32'h5,          32'h0,          4'd7},
    '{2'd1, 12'h008, 32'h0,          32'h5,          4'd7},  // R7 mask
    '{2'd0, 12'h014, 32'h5355,       32'h0,          4'd3},
    '{2'd1, 12'h014, 32'h0,          32'h5355,       4'd3},  // R3 event select
    '{2'd0, 12'h000, 32'h7,          32'h0,          4'd3}
  };

  logic [31:0] mNoise = '0;
  logic [11:0] mq [$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busRe = 1'b1; busAddr = a;
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata;
  endtask

  task automatic pulseTrig();
    @(negedge clk);
    trigPulse = 1'b1;
    @(negedge clk);
    trigPulse = 1'b0;
  endtask

  task automatic stepNoise(output logic [11:0] s);
    mNoise = mNoise * 32'd314159 + 32'd1;
    s = 12'h200 + {9'd0, mNoise[18:16]};
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFail++;
    nChecks++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin : stim
    logic [31:0] rd;
    logic [11:0] s1, s2, firstB, tmp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 irqOut reset", {28'd0, irqOut}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].op == 2'd0) busWrite(VEC[i].addr, VEC[i].data);
      else begin
        busRead(VEC[i].addr, rd);
        chk($sformatf("R%0d table row %0d", VEC[i].req, i), rd, VEC[i].exp);
      end
    end

    // R3 routing, R4 ascending order: seq0,seq1 served; seq2 wrong event, seq3 disabled
    stepNoise(s1); stepNoise(s2);
    pulseTrig();
    busRead(12'h04C, rd); chk("R3 seq0 status", rd, 32'h010);
    busRead(12'h06C, rd); chk("R3 seq1 status", rd, 32'h010);
    busRead(12'h08C, rd); chk("R3 seq2 event mismatch", rd, 32'h100);
    busRead(12'h0AC, rd); chk("R3 seq3 disabled", rd, 32'h100);
    busRead(12'h004, rd); chk("R7 raw set", rd, 32'h3);
    chk("R7 irqOut masked", {28'd0, irqOut}, 32'h1);
    busRead(12'h00C, rd); chk("R8 clear reg read", rd, 32'h1);
    busRead(12'h048, rd); chk("R4 seq0 sample", rd, {20'd0, s1});
    busRead(12'h068, rd); chk("R4 seq1 sample", rd, {20'd0, s2});
    busRead(12'h04C, rd); chk("R6 pop to empty", rd, 32'h111);
    busWrite(12'h00C, 32'h1);
    busRead(12'h004, rd); chk("R8 clear bit0", rd, 32'h2);
    chk("R7 irqOut after clear", {28'd0, irqOut}, 32'h0);

    // R5 fill seq0 to full, then a dropped store
    busWrite(12'h000, 32'h1);
    for (int k = 0; k < 15; k++) begin
      stepNoise(tmp); mq.push_back(tmp);
      pulseTrig();
    end
    firstB = mq[0];
    busRead(12'h04C, rd); chk("R5 fifteen stores", rd, 32'h001);
    stepNoise(tmp); mq.push_back(tmp);
    pulseTrig();
    busRead(12'h04C, rd); chk("R5 full", rd, 32'h1011);
    stepNoise(tmp);
    pulseTrig();
    busRead(12'h04C, rd); chk("R5 store into full dropped", rd, 32'h1011);

    // R6 drain in order
    busRead(12'h048, rd); chk("R6 first pop data", rd, {20'd0, mq.pop_front()});
    busRead(12'h04C, rd); chk("R6 full cleared", rd, 32'h012);
    for (int k = 0; k < 15; k++) begin
      busRead(12'h048, rd); chk("R6 drain data", rd, {20'd0, mq.pop_front()});
    end
    busRead(12'h04C, rd); chk("R6 empty after drain", rd, 32'h111);
    busRead(12'h048, rd); chk("R6 pop of empty data", rd, {20'd0, firstB});
    busRead(12'h04C, rd); chk("R6 pop of empty status", rd, 32'h111);

    // R8 set wins over simultaneous clear
    busWrite(12'h008, 32'hF);
    chk("R7 irqOut full mask", {28'd0, irqOut}, 32'h3);
    stepNoise(tmp);
    @(negedge clk);
    busWe = 1'b1; busAddr = 12'h00C; busWdata = 32'h1; trigPulse = 1'b1;
    @(negedge clk);
    busWe = 1'b0; trigPulse = 1'b0;
    busRead(12'h004, rd); chk("R8 set beats clear", rd, 32'h3);
    busRead(12'h04C, rd); chk("R5 store after wrap", rd, 32'h021);
    busRead(12'h048, rd); chk("R4 sample after mixed cycle", rd, {20'd0, tmp});
    busWrite(12'h00C, 32'h3);
    chk("R8 clear all", {28'd0, irqOut}, 32'h0);

    // R1 reset mid-run restores status and noise seed
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    mNoise = '0;
    busRead(12'h04C, rd); chk("R1 status after reset", rd, 32'h100);
    busRead(12'h014, rd); chk("R1 event after reset", rd, 32'h0);
    busRead(12'h008, rd); chk("R1 mask after reset", rd, 32'h0);
    busWrite(12'h000, 32'h1);
    busWrite(12'h014, 32'h5);
    stepNoise(tmp);
    pulseTrig();
    busRead(12'h048, rd); chk("R4 noise seed after reset", rd, {20'd0, tmp});

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule